// File: doc/BRIEF.md
# Monoshot Frame Capture Sequencer

This block controls when a low-power sensor front end wakes up and captures frames. In monoshot mode it holds the front end asleep until a trigger arrives. The trigger is either a qualified single-cycle pulse from an external pin or a trigger bit that software has set in a register. When a trigger is accepted, the block drops its sleep request and counts a programmed power-up delay. It then issues a one-cycle frame-start strobe and counts frame-done indications from the capture path until the programmed number of frames is reached. At that point it pulses a clear for the software trigger bit and requests sleep again.

In continuous mode the block ignores triggers and keeps the front end awake. It issues a frame-start strobe on entry and another one after every frame-done. Any trigger that arrives while a sequence is running is dropped, not queued. The block also flags mode encodings that are not valid, and delay settings that are too short for the front end to leave deep sleep.

Top module: `frame_wake_seq`

## Requirements
- R1: After reset, sleep_req is 1, and busy, frame_start and sw_trig_clr are 0.
- R2: In monoshot mode (mode_sel = 3), a pin_trig pulse seen while asleep sets busy=1 and sleep_req=0 in the next cycle. frame_start is high exactly 64·D + 2 cycles after the trigger cycle, where D is delay_units.
- R3: A sw_trig level seen while asleep in monoshot mode starts the same sequence with the same 64·D + 2 cycle timing.
- R4: Each frame-start strobe lasts one cycle. During a capture, a frame_done that is not the last one gives a frame_start in the next cycle, so a run yields exactly N strobes, where N is frame_total.
- R5: A frame_total of 0 captures exactly one frame.
- R6: The cycle after the last frame's frame_done, sw_trig_clr pulses for one cycle while sleep_req=1 and busy=0. The software trigger bit is therefore cleared.
- R7: Triggers on either source during the delay or the capture are dropped. A trigger bit that is still set during the clear cycle does not start a new sequence.
- R8: A pin trigger and a software trigger in the same cycle start only one sequence.
- R9: In continuous mode (mode_sel = 0), sleep_req is 0. A strobe comes the cycle after entering the mode and the cycle after each frame_done. Triggers are ignored. When the mode leaves 0, the block returns to sleep.
- R10: For mode_sel 1 or 2, mode_bad is 1 from the next cycle, the block stays asleep, and triggers start nothing.
- R11: delay_bad is 1, one cycle after delay_units changes, exactly when 64·D + 2 < 16000 cycles (D < 250).
- R12: frame_done has no effect while asleep or during the power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 25 ns period in the target system |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 continuous, 3 monoshot, 1 and 2 invalid |
| delay_units | input | 14 | Power-up delay D in units of 64 clocks |
| frame_total | input | 6 | Frames per trigger (0 means 1) |
| pin_trig | input | 1 | Qualified single-cycle pulse from the trigger pin |
| sw_trig | input | 1 | Software trigger bit level from the register |
| frame_done | input | 1 | Data-ready of a frame from the capture path |
| sleep_req | output | 1 | Deep-sleep request level |
| busy | output | 1 | A sequence or continuous capture is running |
| frame_start | output | 1 | One-cycle frame-start strobe |
| sw_trig_clr | output | 1 | One-cycle clear pulse for the software trigger bit |
| mode_bad | output | 1 | mode_sel holds an invalid encoding |
| delay_bad | output | 1 | delay_units gives less than the minimum wake time |

## Verification
The bench checks the delay at D = 0, at small values and at the first legal value of 250. An off-by-one in the unit scaling or in the fixed 2-cycle offset shows up as a strobe one cycle early or late. Back-to-back frame_done with no gap, and a frame count of zero, target frame counters that either skip the last frame or wrap to 63. The bench also models the trigger register so that the bit is still set during the clear cycle. A design without the clear-cycle guard would start a second sequence there. Pulses on both trigger sources and on frame_done are injected during the delay and the capture; a design that queues or counts them would produce extra strobes.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_CAPT  = 2'd2,
    ST_CONT  = 2'd3
  } fws_state_e;

  localparam logic [1:0] MODE_CONT = 2'd0;
  localparam logic [1:0] MODE_MONO = 2'd3;

  // Trigger-capture register plus strobe register give a fixed 2-cycle offset.
  localparam int FIXED_OFFSET = 2;
endpackage

// File: rtl/fws_delay_timer.sv
module fws_delay_timer #(
  parameter int DELAY_W    = 14,
  parameter int UNIT_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DELAY_W-1:0] units,
  output logic               hit
);
  localparam int CNT_W = DELAY_W + UNIT_SHIFT;

  logic [CNT_W-1:0]   cnt_q;
  logic [DELAY_W-1:0] units_q;
  logic               run_q;
  logic [CNT_W-1:0]   target;

  assign target = {units_q, {UNIT_SHIFT{1'b0}}};
  assign hit    = run_q && (cnt_q == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      units_q <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      cnt_q   <= '0;
      units_q <= units;
      run_q   <= 1'b1;
    end else if (hit) begin
      run_q   <= 1'b0;
    end else if (run_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fws_frame_tally.sv
module fws_frame_tally #(
  parameter int FRAMES_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [FRAMES_W-1:0] total,
  input  logic                dec,
  output logic                last
);
  logic [FRAMES_W-1:0] left_q;

  assign last = (left_q <= FRAMES_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= FRAMES_W'(1);
    end else if (load) begin
      left_q <= (total == '0) ? FRAMES_W'(1) : total;
    end else if (dec && !last) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/fws_wake_check.sv
module fws_wake_check #(
  parameter int DELAY_W         = 14,
  parameter int UNIT_SHIFT      = 6,
  parameter int MIN_WAKE_CYCLES = 16000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DELAY_W-1:0] units,
  output logic               too_short
);
  import fws_pkg::*;

  localparam int SUM_W = DELAY_W + UNIT_SHIFT + 1;

  logic [SUM_W-1:0] total_cycles;

  assign total_cycles = {1'b0, units, {UNIT_SHIFT{1'b0}}} + SUM_W'(FIXED_OFFSET);

  always_ff @(posedge clk) begin
    if (rst) too_short <= 1'b0;
    else     too_short <= (total_cycles < SUM_W'(MIN_WAKE_CYCLES));
  end
endmodule

// File: rtl/frame_wake_seq.sv
module frame_wake_seq #(
  parameter int DELAY_W         = 14,
  parameter int FRAMES_W        = 6,
  parameter int UNIT_SHIFT      = 6,
  parameter int MIN_WAKE_CYCLES = 16000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_sel,
  input  logic [DELAY_W-1:0]  delay_units,
  input  logic [FRAMES_W-1:0] frame_total,
  input  logic                pin_trig,
  input  logic                sw_trig,
  input  logic                frame_done,
  output logic                sleep_req,
  output logic                busy,
  output logic                frame_start,
  output logic                sw_trig_clr,
  output logic                mode_bad,
  output logic                delay_bad
);
  import fws_pkg::*;

  fws_state_e state_q, state_n;
  logic strobe_n, clr_n, dec_n;
  logic trig_any, accept, delay_hit, last_frame;

  // The software bit is still set during the clear cycle; mask it there.
  assign trig_any = pin_trig | (sw_trig & ~sw_trig_clr);
  assign accept   = (state_q == ST_SLEEP) && (mode_sel == MODE_MONO) && trig_any;

  fws_delay_timer #(.DELAY_W(DELAY_W), .UNIT_SHIFT(UNIT_SHIFT)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .units (delay_units),
    .hit   (delay_hit)
  );

  fws_frame_tally #(.FRAMES_W(FRAMES_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .total (frame_total),
    .dec   (dec_n),
    .last  (last_frame)
  );

  fws_wake_check #(
    .DELAY_W(DELAY_W), .UNIT_SHIFT(UNIT_SHIFT), .MIN_WAKE_CYCLES(MIN_WAKE_CYCLES)
  ) u_wake (
    .clk       (clk),
    .rst       (rst),
    .units     (delay_units),
    .too_short (delay_bad)
  );

  always_comb begin
    state_n  = state_q;
    strobe_n = 1'b0;
    clr_n    = 1'b0;
    dec_n    = 1'b0;
    case (state_q)
      ST_SLEEP: begin
        if (mode_sel == MODE_CONT) begin
          state_n  = ST_CONT;
          strobe_n = 1'b1;
        end else if (accept) begin
          state_n = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (delay_hit) begin
          state_n  = ST_CAPT;
          strobe_n = 1'b1;
        end
      end
      ST_CAPT: begin
        if (frame_done) begin
          dec_n = 1'b1;
          if (last_frame) begin
            state_n = ST_SLEEP;
            clr_n   = 1'b1;
          end else begin
            strobe_n = 1'b1;
          end
        end
      end
      ST_CONT: begin
        if (mode_sel != MODE_CONT) state_n = ST_SLEEP;
        else if (frame_done)       strobe_n = 1'b1;
      end
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SLEEP;
      sleep_req   <= 1'b1;
      busy        <= 1'b0;
      frame_start <= 1'b0;
      sw_trig_clr <= 1'b0;
      mode_bad    <= 1'b0;
    end else begin
      state_q     <= state_n;
      sleep_req   <= (state_n == ST_SLEEP);
      busy        <= (state_n != ST_SLEEP);
      frame_start <= strobe_n;
      sw_trig_clr <= clr_n;
      mode_bad    <= (mode_sel == 2'd1) || (mode_sel == 2'd2);
    end
  end
endmodule

// File: rtl/fws_checker.sv
module fws_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       pin_trig,
  input logic       frame_done,
  input logic       sleep_req,
  input logic       busy,
  input logic       frame_start,
  input logic       sw_trig_clr
);
  p_sleep_busy_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(sleep_req && busy));

  p_pin_wakes_r2: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && mode_sel == 2'd3 && pin_trig) |=> (busy && !sleep_req));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !frame_done) |=> !frame_start);

  p_clr_single_r6: assert property (@(posedge clk) disable iff (rst)
    sw_trig_clr |=> !sw_trig_clr);

  p_clr_asleep_r6: assert property (@(posedge clk) disable iff (rst)
    sw_trig_clr |-> (sleep_req && !busy));

  p_cont_wakes_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && mode_sel == 2'd0) |=> (!sleep_req && frame_start));

  p_bad_mode_sleeps_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && (mode_sel == 2'd1 || mode_sel == 2'd2)) |=> (sleep_req && !frame_start));
endmodule

bind frame_wake_seq fws_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_sel    (mode_sel),
  .pin_trig    (pin_trig),
  .frame_done  (frame_done),
  .sleep_req   (sleep_req),
  .busy        (busy),
  .frame_start (frame_start),
  .sw_trig_clr (sw_trig_clr)
);

// File: tb/frame_wake_seq_tb.sv
module frame_wake_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd3;
  logic [13:0] delay_units = '0;
  logic [5:0]  frame_total = 6'd1;
  logic        pin_trig = 1'b0;
  logic        sw_wr = 1'b0;
  logic        sw_bit = 1'b0;
  logic        frame_done = 1'b0;
  logic        sleep_req, busy, frame_start, sw_trig_clr, mode_bad, delay_bad;

  int cyc = 0;
  int drv_checks = 0, drv_errs = 0;
  int mon_checks = 0, mon_errs = 0;
  int exp_fs[$];
  int exp_clr[$];

  always #2 clk = ~clk;

  frame_wake_seq u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .delay_units(delay_units),
    .frame_total(frame_total), .pin_trig(pin_trig), .sw_trig(sw_bit),
    .frame_done(frame_done), .sleep_req(sleep_req), .busy(busy),
    .frame_start(frame_start), .sw_trig_clr(sw_trig_clr),
    .mode_bad(mode_bad), .delay_bad(delay_bad)
  );

  // Cycle counter and a model of the software trigger register.
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    sw_bit <= sw_wr ? 1'b1 : (sw_trig_clr ? 1'b0 : sw_bit);
  end

  // Scoreboard monitor: every strobe and clear must match a queued cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_start) begin
        mon_checks++;
        if (exp_fs.size() == 0) begin
          mon_errs++;
          $display("FAIL R2/R4/R7 unexpected frame_start: got cycle %0d expected none", cyc);
        end else begin
          int e;
          e = exp_fs.pop_front();
          if (e != cyc) begin
            mon_errs++;
            $display("FAIL R2/R3/R4 frame_start cycle: got %0d expected %0d", cyc, e);
          end
        end
      end
      if (sw_trig_clr) begin
        mon_checks++;
        if (exp_clr.size() == 0) begin
          mon_errs++;
          $display("FAIL R6 unexpected sw_trig_clr: got cycle %0d expected none", cyc);
        end else begin
          int e;
          e = exp_clr.pop_front();
          if (e != cyc) begin
            mon_errs++;
            $display("FAIL R6 sw_trig_clr cycle: got %0d expected %0d", cyc, e);
          end
        end
      end
    end
  end

  task automatic summary(input int extra);
    $display("Result: errors=%0d of %0d checks",
             drv_errs + mon_errs + extra, drv_checks + mon_checks + extra);
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: got cycle %0d expected under 150000", cyc);
      summary(1);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    drv_checks++;
    if (!ok) begin
      drv_errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic queues_empty(input string req);
    chk(exp_fs.size() == 0, req, "pending strobes", exp_fs.size(), 0);
    chk(exp_clr.size() == 0, req, "pending clears", exp_clr.size(), 0);
  endtask

  // One monoshot sequence; the trigger lands in cycle tt.
  task automatic run_mono(input bit use_pin, input bit use_sw, input int d,
                          input int n, input int gap, input bit intrude);
    int tt, s, dcy, nf;
    delay_units = d[13:0];
    frame_total = n[5:0];
    step; step;
    if (use_sw) sw_wr = 1'b1;
    step;
    sw_wr = 1'b0;
    if (use_pin) pin_trig = 1'b1;
    tt = cyc;
    s = tt + 64 * d + 2;
    exp_fs.push_back(s);
    step;
    pin_trig = 1'b0;
    chk(busy == 1'b1 && sleep_req == 1'b0, use_pin ? "R2" : "R3",
        "awake after trigger (busy)", busy, 1);
    if (intrude) begin
      // R7 and R12: trigger and frame_done during the power-up delay
      step;
      pin_trig = 1'b1;
      frame_done = 1'b1;
      step;
      pin_trig = 1'b0;
      frame_done = 1'b0;
      sw_wr = 1'b1;
      step;
      sw_wr = 1'b0;
    end
    nf = (n == 0) ? 1 : n;
    for (int k = 0; k < nf; k++) begin
      while (cyc < s) step;
      repeat (gap) begin
        step;
        pin_trig = intrude;
      end
      frame_done = 1'b1;
      dcy = cyc;
      if (k < nf - 1) begin
        s = dcy + 1;
        exp_fs.push_back(s);
      end else begin
        exp_clr.push_back(dcy + 1);
      end
      step;
      frame_done = 1'b0;
      pin_trig = 1'b0;
    end
    chk(sleep_req == 1'b1 && busy == 1'b0, "R6", "asleep in clear cycle (sleep_req)",
        sleep_req, 1);
    repeat (8) step;
    queues_empty("R7");
    chk(sw_bit == 1'b0, "R6", "software trigger bit cleared", sw_bit, 0);
  endtask

  initial begin
    int m, s;
    repeat (3) step;
    rst = 1'b0;
    step;
    chk(sleep_req == 1'b1, "R1", "reset sleep_req", sleep_req, 1);
    chk(busy == 1'b0 && frame_start == 1'b0 && sw_trig_clr == 1'b0, "R1",
        "reset busy/strobe/clear", busy | frame_start | sw_trig_clr, 0);

    run_mono(1'b1, 1'b0, 0, 1, 0, 1'b0);   // R2 shortest delay
    run_mono(1'b1, 1'b0, 1, 3, 0, 1'b0);   // R4 back-to-back frames
    run_mono(1'b0, 1'b1, 2, 2, 3, 1'b0);   // R3, R6, R7 clear-cycle guard
    run_mono(1'b1, 1'b0, 3, 0, 1, 1'b0);   // R5 zero frame count
    run_mono(1'b1, 1'b1, 1, 2, 2, 1'b0);   // R8 simultaneous sources
    run_mono(1'b1, 1'b0, 2, 2, 1, 1'b1);   // R7, R12 intrusions
    run_mono(1'b0, 1'b1, 250, 1, 0, 1'b0); // R3 first legal delay

    // R12: frame_done while asleep
    frame_done = 1'b1;
    step;
    frame_done = 1'b0;
    repeat (5) step;
    chk(sleep_req == 1'b1, "R12", "asleep after idle frame_done", sleep_req, 1);
    queues_empty("R12");

    // R9: continuous mode
    mode_sel = 2'd0;
    m = cyc;
    s = m + 1;
    exp_fs.push_back(s);
    for (int k = 0; k < 3; k++) begin
      while (cyc < s) step;
      chk(sleep_req == 1'b0, "R9", "continuous sleep_req", sleep_req, 0);
      pin_trig = 1'b1;
      step;
      pin_trig = 1'b0;
      repeat (k) step;
      frame_done = 1'b1;
      s = cyc + 1;
      exp_fs.push_back(s);
      step;
      frame_done = 1'b0;
    end
    while (cyc < s) step;
    mode_sel = 2'd3;
    step; step;
    chk(sleep_req == 1'b1 && busy == 1'b0, "R9", "asleep after leaving continuous",
        sleep_req, 1);
    repeat (4) step;
    queues_empty("R9");

    // R10: invalid mode encodings
    for (int v = 1; v <= 2; v++) begin
      mode_sel = v[1:0];
      step;
      chk(mode_bad == 1'b1, "R10", "mode_bad for invalid mode", mode_bad, 1);
      pin_trig = 1'b1;
      step;
      pin_trig = 1'b0;
      repeat (5) step;
      chk(sleep_req == 1'b1, "R10", "asleep in invalid mode", sleep_req, 1);
    end
    queues_empty("R10");
    mode_sel = 2'd3;
    step; step;
    chk(mode_bad == 1'b0, "R10", "mode_bad clears in monoshot", mode_bad, 0);

    // R11: minimum wake delay flag
    delay_units = 14'd0;   step;
    chk(delay_bad == 1'b1, "R11", "delay_bad at D=0", delay_bad, 1);
    delay_units = 14'd249; step;
    chk(delay_bad == 1'b1, "R11", "delay_bad at D=249", delay_bad, 1);
    delay_units = 14'd250; step;
    chk(delay_bad == 1'b0, "R11", "delay_bad at D=250", delay_bad, 0);
    delay_units = 14'h3FFF; step;
    chk(delay_bad == 1'b0, "R11", "delay_bad at max D", delay_bad, 0);

    repeat (4) step;
    summary(0);
    $finish;
  end
endmodule